// File: doc/BRIEF.md
# Sequence-Unlocked IDE Configuration Register Bank

This block sits in the command-block I/O window of a legacy parallel-ATA channel, between a byte-addressed host bus and the task-file registers. While it is locked, every host access passes straight through to the task file. A fixed in-band sequence opens a hidden bank: two consecutive 16-bit reads at offset 1, then a byte write of 0x03 to offset 2. While the bank is open, byte writes land in configuration registers and do not reach the task file. A byte write of 0x83 to offset 2 closes the bank again.

The bank holds a read-cycle timing value and a write-cycle timing value for each of the two devices, one shared address-setup code, a control register and a strap register. A device-select field steers the timing writes to one of the two devices. Once the control register holds 0x85, the cycle generator receives the programmed timings of the device currently addressed through the task file. Until then it receives the slowest defaults. A separate probe reports the strapped bus-clock selection: a byte write of 0xFF to offset 5 arms it, and the next access, a 16-bit read at offset 5, returns that selection.

Top module: `ide_cfg_trapdoor`

## Requirements
- R1: After reset the bank is closed, `override_o` is 0, both timing outputs read 0x6B, `setup_code_o` reads 3 and `strap_o` reads 0.
- R2: Two back-to-back 16-bit reads at offset 1, followed directly by a byte write of 0x03 at offset 2, open the bank (`bank_open_o` = 1) from the cycle after the write.
- R3: If any other access comes between or in place of those steps (an 8-bit read at offset 1, a read at another offset, a third 16-bit read, a wrong data value or a wrong offset), the tracker returns to idle and the bank stays closed.
- R4: While the bank is closed, reads and writes appear on the task-file port with the same offset, data and width. A read has priority over nothing: a simultaneous read and write counts as a write only.
- R5: While the bank is open, a byte write at offset 0 sets the read timing and one at offset 1 sets the write timing of the device picked by the device-select field. These writes never reach the task file. Reads still pass through.
- R6: An open byte write at offset 6 loads the device select from data bit 0. It updates the shared setup code from data bits 5:4 only when that field is nonzero.
- R7: `override_o` is 1 exactly while the control register (offset 3) holds 0x85. With override on, the outputs show the programmed values. With it off, they show 0x6B, 0x6B and code 3.
- R8: The addressed device is data bit 4 of the last pass-through byte write at offset 6. It picks which device's timing pair is driven out.
- R9: While the bank is open, a byte write of 0x83 at offset 2 closes it from the next cycle. That write does not reach the task file, and later writes pass through again.
- R10: A byte write of 0xFF at offset 5 while the bank is closed arms the strap probe. If the very next access is a 16-bit read at offset 5, `hb_rdata_o` bit 0 equals `clk_sel_i` and bits 15:1 come from the task file. Any other access disarms the probe.
- R11: While the bank is open, 16-bit writes and byte writes at offsets 2 (other than 0x83), 4 and 7 change no output. A byte write at offset 5 loads `strap_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hb_addr_i | input | 3 | Host offset in the command window |
| hb_rd_i | input | 1 | Host read strobe |
| hb_wr_i | input | 1 | Host write strobe |
| hb_wide_i | input | 1 | 1 = 16-bit access, 0 = byte access |
| hb_wdata_i | input | 16 | Host write data (byte in bits 7:0) |
| hb_rdata_o | output | 16 | Host read data |
| tf_rd_o | output | 1 | Task-file read strobe |
| tf_wr_o | output | 1 | Task-file write strobe |
| tf_addr_o | output | 3 | Task-file offset |
| tf_wide_o | output | 1 | Task-file access width |
| tf_wdata_o | output | 16 | Task-file write data |
| tf_rdata_i | input | 16 | Task-file read data |
| clk_sel_i | input | 1 | Strapped bus-clock selection |
| bank_open_o | output | 1 | Configuration bank is open |
| rd_timing_o | output | 8 | Read data/recovery timing for the addressed device |
| wr_timing_o | output | 8 | Write data/recovery timing for the addressed device |
| setup_code_o | output | 2 | Shared address-setup code |
| override_o | output | 1 | Programmed timings override defaults |
| strap_o | output | 8 | Strap register contents |

## Verification
A wrong tracker state shows in the cycle after the third step: either `bank_open_o` rises after a broken sequence, or a write that should land in the bank appears on `tf_wr_o`. A corrupted device select or a misdirected timing write stays hidden until override is enabled and the matching device is addressed. For that reason the stimulus programs both devices with distinct values and then switches the addressed device. Errors in the strap probe show only in bit 0 of the read data, during the single read that follows the arming write. The task-file data used there therefore differs from the strap value in bit 0.

// File: rtl/ide_cfg_pkg.sv
package ide_cfg_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;
  localparam int NUM_DEV = 2;

  typedef enum logic [1:0] {TRK_IDLE = 2'd0, TRK_ONE = 2'd1, TRK_TWO = 2'd2} trk_e;

  localparam logic [ADDR_W-1:0] OFS_RDT   = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_WRT   = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_PROBE = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_KEY   = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_CTL   = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_STRAP = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_MISC  = 3'd6;
  localparam logic [ADDR_W-1:0] OFS_HEAD  = 3'd6;

  localparam logic [BYTE_W-1:0] KEY_OPEN  = 8'h03;
  localparam logic [BYTE_W-1:0] KEY_CLOSE = 8'h83;
  localparam logic [BYTE_W-1:0] CTL_OVR   = 8'h85;
  localparam logic [BYTE_W-1:0] STRAP_ARM = 8'hFF;
endpackage

// File: rtl/ide_unlock_fsm.sv
module ide_unlock_fsm
  import ide_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic              open_o
);
  trk_e trk_q;
  logic open_q;
  logic probe_rd, key_wr, close_wr;

  assign probe_rd = rd_i & wide_i & (addr_i == OFS_PROBE);
  assign key_wr   = wr_i & ~wide_i & (addr_i == OFS_KEY) & (wdata_i == KEY_OPEN);
  assign close_wr = wr_i & ~wide_i & (addr_i == OFS_KEY) & (wdata_i == KEY_CLOSE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trk_q  <= TRK_IDLE;
      open_q <= 1'b0;
    end else if (rd_i | wr_i) begin
      if (open_q) begin
        trk_q <= TRK_IDLE;
        if (close_wr) open_q <= 1'b0;
      end else if (probe_rd) begin
        unique case (trk_q)
          TRK_IDLE: trk_q <= TRK_ONE;
          TRK_ONE:  trk_q <= TRK_TWO;
          default:  trk_q <= TRK_IDLE;
        endcase
      end else if (key_wr && trk_q == TRK_TWO) begin
        trk_q  <= TRK_IDLE;
        open_q <= 1'b1;
      end else begin
        trk_q <= TRK_IDLE;
      end
    end
  end

  assign open_o = open_q;
endmodule

// File: rtl/ide_cfg_regs.sv
module ide_cfg_regs
  import ide_cfg_pkg::*;
#(
  parameter int               TIM_W      = 8,
  parameter logic [TIM_W-1:0] DEF_TIMING = 8'h6B,
  parameter logic [1:0]       DEF_SETUP  = 2'd3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              act_dev_i,
  output logic [TIM_W-1:0]  rd_tim_o,
  output logic [TIM_W-1:0]  wr_tim_o,
  output logic [1:0]        setup_o,
  output logic              override_o,
  output logic [BYTE_W-1:0] strap_o
);
  logic [TIM_W-1:0]  rd_arr [NUM_DEV];
  logic [TIM_W-1:0]  wr_arr [NUM_DEV];
  logic              sel_q;
  logic [1:0]        setup_q;
  logic [BYTE_W-1:0] ctrl_q, strap_q;

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic [TIM_W-1:0] rd_r, wr_r;
    logic hit;
    assign hit = we_i & (sel_q == 1'(d));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rd_r <= DEF_TIMING;
        wr_r <= DEF_TIMING;
      end else if (hit) begin
        if (addr_i == OFS_RDT) rd_r <= wdata_i[TIM_W-1:0];
        if (addr_i == OFS_WRT) wr_r <= wdata_i[TIM_W-1:0];
      end
    end
    assign rd_arr[d] = rd_r;
    assign wr_arr[d] = wr_r;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= 1'b0;
      setup_q <= DEF_SETUP;
      ctrl_q  <= '0;
      strap_q <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        OFS_CTL:   ctrl_q  <= wdata_i;
        OFS_STRAP: strap_q <= wdata_i;
        OFS_MISC: begin
          sel_q <= wdata_i[0];
          if (wdata_i[5:4] != 2'd0) setup_q <= wdata_i[5:4];
        end
        default: ;
      endcase
    end
  end

  assign override_o = (ctrl_q == CTL_OVR);
  assign rd_tim_o   = override_o ? rd_arr[act_dev_i] : DEF_TIMING;
  assign wr_tim_o   = override_o ? wr_arr[act_dev_i] : DEF_TIMING;
  assign setup_o    = override_o ? setup_q : DEF_SETUP;
  assign strap_o    = strap_q;
endmodule

// File: rtl/ide_strap_probe.sv
module ide_strap_probe
  import ide_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              wide_i,
  input  logic              open_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              clk_sel_i,
  input  logic [DATA_W-1:0] tf_rdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic arm_q, hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arm_q <= 1'b0;
    else if (rd_i | wr_i)
      arm_q <= wr_i & ~wide_i & ~open_i & (addr_i == OFS_STRAP) & (wdata_i == STRAP_ARM);
  end

  assign hit     = arm_q & rd_i & wide_i & (addr_i == OFS_STRAP);
  assign rdata_o = hit ? {tf_rdata_i[DATA_W-1:1], clk_sel_i} : tf_rdata_i;
endmodule

// File: rtl/ide_cfg_trapdoor.sv
module ide_cfg_trapdoor
  import ide_cfg_pkg::*;
#(
  parameter int               TIM_W      = 8,
  parameter logic [TIM_W-1:0] DEF_TIMING = 8'h6B,
  parameter logic [1:0]       DEF_SETUP  = 2'd3,
  parameter int               DEV_BIT    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        hb_addr_i,
  input  logic              hb_rd_i,
  input  logic              hb_wr_i,
  input  logic              hb_wide_i,
  input  logic [15:0]       hb_wdata_i,
  output logic [15:0]       hb_rdata_o,
  output logic              tf_rd_o,
  output logic              tf_wr_o,
  output logic [2:0]        tf_addr_o,
  output logic              tf_wide_o,
  output logic [15:0]       tf_wdata_o,
  input  logic [15:0]       tf_rdata_i,
  input  logic              clk_sel_i,
  output logic              bank_open_o,
  output logic [TIM_W-1:0]  rd_timing_o,
  output logic [TIM_W-1:0]  wr_timing_o,
  output logic [1:0]        setup_code_o,
  output logic              override_o,
  output logic [7:0]        strap_o
);
  logic rd_en, wr_en, open_w, act_q, cfg_we;

  assign rd_en  = hb_rd_i & ~hb_wr_i;
  assign wr_en  = hb_wr_i;
  assign cfg_we = wr_en & ~hb_wide_i & open_w;

  assign tf_rd_o    = rd_en;
  assign tf_wr_o    = wr_en & ~open_w;
  assign tf_addr_o  = hb_addr_i;
  assign tf_wide_o  = hb_wide_i;
  assign tf_wdata_o = hb_wdata_i;

  // addressed device follows the pass-through head-register write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 1'b0;
    else if (wr_en && !hb_wide_i && !open_w && hb_addr_i == OFS_HEAD)
      act_q <= hb_wdata_i[DEV_BIT];
  end

  ide_unlock_fsm u_unlock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (rd_en),
    .wr_i    (wr_en),
    .wide_i  (hb_wide_i),
    .addr_i  (hb_addr_i),
    .wdata_i (hb_wdata_i[7:0]),
    .open_o  (open_w)
  );

  ide_cfg_regs #(.TIM_W(TIM_W), .DEF_TIMING(DEF_TIMING), .DEF_SETUP(DEF_SETUP)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we),
    .addr_i     (hb_addr_i),
    .wdata_i    (hb_wdata_i[7:0]),
    .act_dev_i  (act_q),
    .rd_tim_o   (rd_timing_o),
    .wr_tim_o   (wr_timing_o),
    .setup_o    (setup_code_o),
    .override_o (override_o),
    .strap_o    (strap_o)
  );

  ide_strap_probe u_probe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_i       (rd_en),
    .wr_i       (wr_en),
    .wide_i     (hb_wide_i),
    .open_i     (open_w),
    .addr_i     (hb_addr_i),
    .wdata_i    (hb_wdata_i[7:0]),
    .clk_sel_i  (clk_sel_i),
    .tf_rdata_i (tf_rdata_i),
    .rdata_o    (hb_rdata_o)
  );

  assign bank_open_o = open_w;
endmodule

// File: rtl/ide_cfg_trapdoor_chk.sv
module ide_cfg_trapdoor_chk #(
  parameter int               TIM_W      = 8,
  parameter logic [TIM_W-1:0] DEF_TIMING = 8'h6B,
  parameter logic [1:0]       DEF_SETUP  = 2'd3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       hb_addr_i,
  input logic             hb_wr_i,
  input logic             hb_wide_i,
  input logic [15:0]      hb_wdata_i,
  input logic             tf_wr_o,
  input logic             bank_open_o,
  input logic [TIM_W-1:0] rd_timing_o,
  input logic [TIM_W-1:0] wr_timing_o,
  input logic [1:0]       setup_code_o,
  input logic             override_o,
  input logic [1:0]       trk_i
);
  // R2
  open_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bank_open_o) |-> $past(hb_wr_i && !hb_wide_i && hb_addr_i == 3'd2 && hb_wdata_i[7:0] == 8'h03));

  // R3
  open_after_two_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bank_open_o) |-> $past(trk_i) == 2'd2);

  // R9
  close_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bank_open_o) |-> $past(hb_wr_i && !hb_wide_i && hb_addr_i == 3'd2 && hb_wdata_i[7:0] == 8'h83));

  // R5
  no_leak_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_open_o |-> !tf_wr_o);

  // R7
  default_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !override_o |-> (rd_timing_o == DEF_TIMING && wr_timing_o == DEF_TIMING && setup_code_o == DEF_SETUP));

  // R3
  idle_when_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(bank_open_o) && bank_open_o |-> trk_i == 2'd0);
endmodule

bind ide_cfg_trapdoor ide_cfg_trapdoor_chk #(
  .TIM_W(TIM_W), .DEF_TIMING(DEF_TIMING), .DEF_SETUP(DEF_SETUP)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .hb_addr_i    (hb_addr_i),
  .hb_wr_i      (hb_wr_i),
  .hb_wide_i    (hb_wide_i),
  .hb_wdata_i   (hb_wdata_i),
  .tf_wr_o      (tf_wr_o),
  .bank_open_o  (bank_open_o),
  .rd_timing_o  (rd_timing_o),
  .wr_timing_o  (wr_timing_o),
  .setup_code_o (setup_code_o),
  .override_o   (override_o),
  .trk_i        (u_unlock.trk_q)
);

// File: tb/ide_cfg_trapdoor_tb_top.sv
module ide_cfg_trapdoor_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  hb_addr = '0;
  logic        hb_rd = 1'b0, hb_wr = 1'b0, hb_wide = 1'b0;
  logic [15:0] hb_wdata = '0, tf_rdata = 16'hA5A4;
  logic        clk_sel = 1'b1;
  logic [15:0] hb_rdata, tf_wdata;
  logic        tf_rd, tf_wr, tf_wide, bank_open, override;
  logic [2:0]  tf_addr;
  logic [7:0]  rd_t, wr_t, strap;
  logic [1:0]  setup;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ide_cfg_trapdoor dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hb_addr_i(hb_addr), .hb_rd_i(hb_rd), .hb_wr_i(hb_wr),
    .hb_wide_i(hb_wide), .hb_wdata_i(hb_wdata), .hb_rdata_o(hb_rdata), .tf_rd_o(tf_rd),
    .tf_wr_o(tf_wr), .tf_addr_o(tf_addr), .tf_wide_o(tf_wide), .tf_wdata_o(tf_wdata),
    .tf_rdata_i(tf_rdata), .clk_sel_i(clk_sel), .bank_open_o(bank_open),
    .rd_timing_o(rd_t), .wr_timing_o(wr_t), .setup_code_o(setup), .override_o(override),
    .strap_o(strap)
  );

  // behavioural reference state
  bit         m_open, m_arm, m_sel, m_act;
  int         m_trk, m_setup;
  logic [7:0] m_rdt [2];
  logic [7:0] m_wrt [2];
  logic [7:0] m_ctrl, m_strap;

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_open = 0; m_arm = 0; m_sel = 0; m_act = 0; m_trk = 0; m_setup = 3;
      m_rdt[0] = 8'h6B; m_rdt[1] = 8'h6B; m_wrt[0] = 8'h6B; m_wrt[1] = 8'h6B;
      m_ctrl = 8'h00; m_strap = 8'h00;
    end else if (hb_rd || hb_wr) begin
      bit rd, bw;
      rd = hb_rd && !hb_wr;
      bw = hb_wr && !hb_wide;
      if (m_open) begin
        m_trk = 0;
        if (bw) begin
          if (hb_addr == 0) m_rdt[m_sel] = hb_wdata[7:0];
          if (hb_addr == 1) m_wrt[m_sel] = hb_wdata[7:0];
          if (hb_addr == 3) m_ctrl = hb_wdata[7:0];
          if (hb_addr == 5) m_strap = hb_wdata[7:0];
          if (hb_addr == 6) begin
            m_sel = hb_wdata[0];
            if (hb_wdata[5:4] != 0) m_setup = int'(hb_wdata[5:4]);
          end
          if (hb_addr == 2 && hb_wdata[7:0] == 8'h83) m_open = 0;
        end
        m_arm = 0;
      end else begin
        if (rd && hb_wide && hb_addr == 1) m_trk = (m_trk + 1) % 3;
        else if (bw && hb_addr == 2 && hb_wdata[7:0] == 8'h03 && m_trk == 2) begin
          m_open = 1; m_trk = 0;
        end else m_trk = 0;
        if (bw && hb_addr == 6) m_act = hb_wdata[4];
        m_arm = bw && hb_addr == 5 && hb_wdata[7:0] == 8'hFF;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit ovr, rd;
      logic [15:0] exp_rd;
      ovr = (m_ctrl == 8'h85);
      rd = hb_rd && !hb_wr;
      exp_rd = (rd && hb_wide && hb_addr == 5 && m_arm) ? {tf_rdata[15:1], clk_sel} : tf_rdata;
      chk("R2 R3 R9 bank_open", 16'(bank_open), 16'(m_open));
      chk("R4 R5 R9 tf_wr", 16'(tf_wr), 16'(hb_wr && !m_open));
      chk("R4 tf_rd", 16'(tf_rd), 16'(rd));
      chk("R4 tf_fields", {tf_addr, tf_wide, 12'h0}, {hb_addr, hb_wide, 12'h0});
      chk("R4 tf_wdata", tf_wdata, hb_wdata);
      chk("R7 override", 16'(override), 16'(ovr));
      chk("R5 R7 R8 rd_timing", 16'(rd_t), 16'(ovr ? m_rdt[m_act] : 8'h6B));
      chk("R5 R7 R8 wr_timing", 16'(wr_t), 16'(ovr ? m_wrt[m_act] : 8'h6B));
      chk("R6 R7 setup", 16'(setup), 16'(ovr ? m_setup : 3));
      chk("R11 strap", 16'(strap), 16'(m_strap));
      chk("R10 rdata", hb_rdata, exp_rd);
    end
  end

  task automatic acc(input bit rd, input bit wr, input bit wide, input logic [2:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    hb_rd = rd; hb_wr = wr; hb_wide = wide; hb_addr = a; hb_wdata = d;
  endtask

  task automatic idle();
    @(posedge clk); #1;
    hb_rd = 0; hb_wr = 0;
  endtask

  task automatic unlock();
    acc(1, 0, 1, 3'd1, 16'h0);
    acc(1, 0, 1, 3'd1, 16'h0);
    acc(0, 1, 0, 3'd2, 16'h0003);
    idle();
  endtask

  task automatic bw(input logic [2:0] a, input logic [7:0] d);
    acc(0, 1, 0, a, {8'h00, d});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle();
    // R1 reset state
    chk("R1 open", 16'(bank_open), 16'h0);
    chk("R1 override", 16'(override), 16'h0);
    chk("R1 timing", {rd_t, wr_t}, 16'h6B6B);
    chk("R1 setup strap", {6'h0, setup, strap}, 16'h0300);
    // R4 locked pass-through
    bw(3'd3, 8'h55);
    acc(0, 1, 1, 3'd0, 16'hBEEF);
    acc(1, 0, 0, 3'd7, 16'h0);
    idle();
    // R3 broken sequences
    acc(1, 0, 1, 3'd1, 16'h0); acc(1, 0, 0, 3'd1, 16'h0); acc(1, 0, 1, 3'd1, 16'h0);
    bw(3'd2, 8'h03); idle();
    chk("R3 byte read breaks", 16'(bank_open), 16'h0);
    acc(1, 0, 1, 3'd1, 16'h0); acc(1, 0, 1, 3'd1, 16'h0); acc(1, 0, 1, 3'd3, 16'h0);
    bw(3'd2, 8'h03); idle();
    chk("R3 other offset breaks", 16'(bank_open), 16'h0);
    acc(1, 0, 1, 3'd1, 16'h0); acc(1, 0, 1, 3'd1, 16'h0); acc(1, 0, 1, 3'd1, 16'h0);
    bw(3'd2, 8'h03); idle();
    chk("R3 third read breaks", 16'(bank_open), 16'h0);
    acc(1, 0, 1, 3'd1, 16'h0); acc(1, 0, 1, 3'd1, 16'h0);
    bw(3'd2, 8'h04); idle();
    chk("R3 wrong key", 16'(bank_open), 16'h0);
    // R2 proper unlock
    unlock();
    chk("R2 open", 16'(bank_open), 16'h1);
    // R5 R6 programming both devices
    bw(3'd6, 8'h01); bw(3'd0, 8'h42); bw(3'd1, 8'h32);
    bw(3'd6, 8'h00); bw(3'd0, 8'h31); bw(3'd1, 8'h21);
    bw(3'd6, 8'h20);
    // R11 ignored writes
    bw(3'd2, 8'h55); bw(3'd4, 8'h77); bw(3'd7, 8'h99);
    acc(0, 1, 1, 3'd0, 16'h1234); acc(0, 1, 1, 3'd3, 16'h0085);
    acc(1, 0, 1, 3'd5, 16'h0);
    bw(3'd5, 8'h9C);
    idle();
    chk("R11 still default", 16'(override), 16'h0);
    bw(3'd3, 8'h85); idle();
    chk("R7 R5 dev0 pair", {rd_t, wr_t}, 16'h3121);
    chk("R6 setup", 16'(setup), 16'h2);
    chk("R11 strap write", 16'(strap), 16'h009C);
    bw(3'd6, 8'h00); idle();
    chk("R6 zero code keeps", 16'(setup), 16'h2);
    // R9 relock
    bw(3'd2, 8'h83); idle();
    chk("R9 closed", 16'(bank_open), 16'h0);
    // R8 switch addressed device
    bw(3'd6, 8'h10); idle();
    chk("R8 dev1 pair", {rd_t, wr_t}, 16'h4232);
    bw(3'd6, 8'hE0); idle();
    chk("R8 dev0 pair", {rd_t, wr_t}, 16'h3121);
    // R10 strap probe
    bw(3'd5, 8'hFF);
    acc(1, 0, 1, 3'd5, 16'h0); #1;
    chk("R10 strap 1", hb_rdata, 16'hA5A5);
    acc(1, 0, 1, 3'd5, 16'h0); #1;
    chk("R10 disarmed", hb_rdata, 16'hA5A4);
    tf_rdata = 16'h5A5B; clk_sel = 0;
    bw(3'd5, 8'hFF);
    acc(1, 0, 1, 3'd5, 16'h0); #1;
    chk("R10 strap 0", hb_rdata, 16'h5A5A);
    bw(3'd5, 8'hFF); acc(1, 0, 0, 3'd5, 16'h0);
    acc(1, 0, 1, 3'd5, 16'h0); #1;
    chk("R10 byte read disarms", hb_rdata, 16'h5A5B);
    // R7 override off again
    unlock();
    bw(3'd3, 8'h00); bw(3'd2, 8'h83); idle();
    chk("R7 defaults back", {rd_t, wr_t}, 16'h6B6B);
    chk("R7 setup default", 16'(setup), 16'h3);
    repeat (3) idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule